// File: doc/BRIEF.md
# External Event Timestamp Capture

This block records the time at which external trigger pins rise. Each trigger input passes through a two-flop synchronizer. When the synchronized level goes from low to high, the block stores the free-running time value supplied on `time_i` into a small queue for that channel. The time counter itself lives outside the block.

Software drains each queue through a word-wide register port. It reads the low half of the oldest stamp and then the high half, and the read of the high half retires that entry. A per-channel valid flag stays up for as long as entries remain, so a drain loop just repeats until the flag drops. Each stored stamp raises that channel's event flag. The event flags are write-one-to-clear and are gated by a mask register to form one interrupt line. Arming a channel through the mask register also discards any stale event of that channel in the same write.

Top module: `ext_stamp_capture`

## Requirements
- R1: A trigger that is sampled high at clock edge k, after being low, stores exactly one stamp at edge k+2. The stored value is the `time_i` value present between edges k+1 and k+2. Holding the trigger high, or letting it fall, stores nothing more.
- R2: Each channel queues up to DEPTH (default 4) stamps and returns them oldest first.
- R3: A rising edge that finds its queue full is dropped and sets that channel's sticky overflow flag, which is status bit NUM_CH+c. The flag clears only when 1 is written to that bit at register 2. A drop in the same cycle as the clear wins.
- R4: Status register 2, bit c, reads 1 exactly while channel c's queue holds at least one stamp.
- R5: Register 4+2c returns bits [31:0] of channel c's oldest stamp. Register 5+2c returns bits [63:32] of that stamp, and a read of 5+2c removes the stamp. On an empty queue both registers read 0 and the read has no effect.
- R6: Every stamp that is stored sets event bit c of register 0.
- R7: Writing register 0 clears each event bit written as 1 and leaves each bit written as 0 unchanged. A stamp stored in the same cycle as the clear leaves its bit set.
- R8: Writing register 1 loads the mask, where bit c belongs to channel c, and clears the event bit of every channel written as 1. Reading register 1 returns the mask.
- R9: `irq_o` is high exactly when some channel has both its event bit and its mask bit set.
- R10: After reset, all queues are empty and the event, mask and overflow flags are zero. `irq_o` is low, and any register address not listed here reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| time_i | input | 2*WORD_W | Current time value to be stamped |
| trig_i | input | NUM_CH | Asynchronous trigger inputs, one per channel |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops on the high data word) |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | WORD_W | Register write data |
| reg_rdata_o | output | WORD_W | Register read data for reg_addr_i, combinational |
| irq_o | output | 1 | Interrupt: any event bit with its mask bit set |

## Verification
The bench builds the block with its defaults: two channels, 32-bit words, a queue depth of 4 and a 4-bit address. With a depth of 4, the fifth pulse on a channel hits a full queue, so the overflow path and its sticky clear can be reached in a few pulses. The time stimulus starts just below a 32-bit boundary, so stored stamps carry into the high word and the two halves of each read are checked separately. The timed cases are a capture landing in the same cycle as an event clear, reads of an empty queue, and a trigger held high for many cycles.

// File: rtl/ext_stamp_pkg.sv
package ext_stamp_pkg;
  localparam int unsigned REG_EVENT     = 0;
  localparam int unsigned REG_MASK      = 1;
  localparam int unsigned REG_STAT      = 2;
  localparam int unsigned REG_DATA_BASE = 4;

  function automatic int unsigned lo_addr(input int unsigned ch);
    return REG_DATA_BASE + 2 * ch;
  endfunction

  function automatic int unsigned hi_addr(input int unsigned ch);
    return REG_DATA_BASE + 2 * ch + 1;
  endfunction
endpackage

// File: rtl/stamp_edge_sync.sv
module stamp_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;
endmodule

// File: rtl/stamp_fifo.sv
module stamp_fifo #(
  parameter int unsigned W     = 64,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end
endmodule

// File: rtl/ext_stamp_capture.sv
module ext_stamp_capture
  import ext_stamp_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [2*WORD_W-1:0]   time_i,
  input  logic [NUM_CH-1:0]     trig_i,
  input  logic                  reg_we_i,
  input  logic                  reg_re_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [WORD_W-1:0]     reg_wdata_i,
  output logic [WORD_W-1:0]     reg_rdata_o,
  output logic                  irq_o
);
  localparam int unsigned TIME_W = 2 * WORD_W;

  logic [NUM_CH-1:0] rise, fifo_full, fifo_empty, cap_stb, pop_stb, valid;
  logic [NUM_CH-1:0] ev_q, ev_d, mask_q, ovf_q, ovf_d;
  logic [WORD_W-1:0] lo_word [NUM_CH];
  logic [WORD_W-1:0] hi_word [NUM_CH];
  logic              wr_ev, wr_mask, wr_stat;
  logic [WORD_W-1:0] unused_wdata;

  assign wr_ev   = reg_we_i && (reg_addr_i == ADDR_W'(REG_EVENT));
  assign wr_mask = reg_we_i && (reg_addr_i == ADDR_W'(REG_MASK));
  assign wr_stat = reg_we_i && (reg_addr_i == ADDR_W'(REG_STAT));
  assign unused_wdata = reg_wdata_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(hi_addr(c));
    logic [TIME_W-1:0] head;

    stamp_edge_sync u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (trig_i[c]),
      .rise_o (rise[c])
    );

    stamp_fifo #(.W(TIME_W), .DEPTH(DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (rise[c]),
      .data_i  (time_i),
      .pop_i   (pop_stb[c]),
      .head_o  (head),
      .full_o  (fifo_full[c]),
      .empty_o (fifo_empty[c])
    );

    assign cap_stb[c] = rise[c] & ~fifo_full[c];
    assign pop_stb[c] = reg_re_i && (reg_addr_i == HI_A) && !fifo_empty[c];
    assign valid[c]   = ~fifo_empty[c];
    assign lo_word[c] = fifo_empty[c] ? '0 : head[WORD_W-1:0];
    assign hi_word[c] = fifo_empty[c] ? '0 : head[TIME_W-1:WORD_W];
  end

  always_comb begin
    ev_d = ev_q;
    if (wr_ev)   ev_d = ev_d & ~reg_wdata_i[NUM_CH-1:0];
    if (wr_mask) ev_d = ev_d & ~reg_wdata_i[NUM_CH-1:0];
    ev_d = ev_d | cap_stb;
    ovf_d = ovf_q;
    if (wr_stat) ovf_d = ovf_d & ~reg_wdata_i[2*NUM_CH-1:NUM_CH];
    ovf_d = ovf_d | (rise & fifo_full);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_q   <= '0;
      mask_q <= '0;
      ovf_q  <= '0;
    end else begin
      ev_q  <= ev_d;
      ovf_q <= ovf_d;
      if (wr_mask) mask_q <= reg_wdata_i[NUM_CH-1:0];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(REG_EVENT))     reg_rdata_o = WORD_W'(ev_q);
    else if (reg_addr_i == ADDR_W'(REG_MASK)) reg_rdata_o = WORD_W'(mask_q);
    else if (reg_addr_i == ADDR_W'(REG_STAT)) reg_rdata_o = WORD_W'({ovf_q, valid});
    else begin
      for (int unsigned i = 0; i < NUM_CH; i++) begin
        if (reg_addr_i == ADDR_W'(lo_addr(i))) reg_rdata_o = lo_word[i];
        if (reg_addr_i == ADDR_W'(hi_addr(i))) reg_rdata_o = hi_word[i];
      end
    end
  end

  assign irq_o = |(ev_q & mask_q);
endmodule

// File: rtl/ext_stamp_capture_chk.sv
module ext_stamp_capture_chk
  import ext_stamp_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [WORD_W-1:0] wdata_i,
  input logic [NUM_CH-1:0] rise_i,
  input logic [NUM_CH-1:0] full_i,
  input logic [NUM_CH-1:0] cap_i,
  input logic [NUM_CH-1:0] pop_i,
  input logic [NUM_CH-1:0] valid_i,
  input logic [NUM_CH-1:0] ev_i,
  input logic [NUM_CH-1:0] mask_i,
  input logic [NUM_CH-1:0] ovf_i
);
  logic wr_ev, wr_mask, wr_stat;
  assign wr_ev   = we_i && (addr_i == ADDR_W'(REG_EVENT));
  assign wr_mask = we_i && (addr_i == ADDR_W'(REG_MASK));
  assign wr_stat = we_i && (addr_i == ADDR_W'(REG_STAT));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_CAP_SETS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap_i[c] |=> ev_i[c]); // R6
    AST_DROP_SETS_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_i[c] && full_i[c] |=> ovf_i[c]); // R3
    AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_i[c] && !(wr_stat && wdata_i[NUM_CH+c]) |=> ovf_i[c]); // R3
    AST_EVENT_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_ev && wdata_i[c] && !cap_i[c] |=> !ev_i[c]); // R7
    AST_EVENT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_i[c] && !((wr_ev || wr_mask) && wdata_i[c]) |=> ev_i[c]); // R7
    AST_ARM_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_mask && wdata_i[c] && !cap_i[c] |=> !ev_i[c] && mask_i[c]); // R8
    AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cap_i[c] && !pop_i[c] |=> $stable(valid_i[c])); // R4
  end
endmodule

bind ext_stamp_capture ext_stamp_capture_chk #(
  .NUM_CH(NUM_CH), .WORD_W(WORD_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (reg_we_i),
  .addr_i  (reg_addr_i),
  .wdata_i (reg_wdata_i),
  .rise_i  (rise),
  .full_i  (fifo_full),
  .cap_i   (cap_stb),
  .pop_i   (pop_stb),
  .valid_i (valid),
  .ev_i    (ev_q),
  .mask_i  (mask_q),
  .ovf_i   (ovf_q)
);

// File: tb/ext_stamp_capture_test.sv
module ext_stamp_capture_test;
  localparam int NCH = 2;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] tval = 64'h0000_0000_FFFF_FF00;
  logic [1:0]  trig = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  logic [63:0] mq [NCH][$];
  logic [1:0]  m_s1 = '0, m_s2 = '0, m_s3 = '0, m_rise;
  logic [1:0]  m_ev = '0, m_mask = '0, m_ovf = '0;
  int          m_sz [NCH];

  ext_stamp_capture uut (
    .clk_i(clk), .rst_ni(rst_n), .time_i(tval), .trig_i(trig),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  always #2 clk = ~clk;

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference, updated on every clock edge
  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
    if (rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_rise[c] = m_s2[c] & ~m_s3[c];
        m_sz[c] = mq[c].size();
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = trig;
      if (we && addr == 0) m_ev = m_ev & ~wdata[1:0];
      if (we && addr == 1) begin m_mask = wdata[1:0]; m_ev = m_ev & ~wdata[1:0]; end
      if (we && addr == 2) m_ovf = m_ovf & ~wdata[3:2];
      for (int c = 0; c < NCH; c++) begin
        if (re && addr == 4'(5 + 2 * c) && m_sz[c] > 0) void'(mq[c].pop_front());
        if (m_rise[c]) begin
          if (m_sz[c] < DEPTH) begin mq[c].push_back(tval); m_ev[c] = 1'b1; end
          else m_ovf[c] = 1'b1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) tval <= tval + 64'd8;
    if (rst_n && !done) check("R9 irq", {31'd0, irq}, {31'd0, |(m_ev & m_mask)});
  end

  function automatic logic [31:0] model_read(input logic [3:0] a);
    logic [1:0] v;
    int ch;
    for (int c = 0; c < NCH; c++) v[c] = (mq[c].size() > 0);
    case (a)
      4'd0: return {30'd0, m_ev};
      4'd1: return {30'd0, m_mask};
      4'd2: return {28'd0, m_ovf, v};
      4'd4, 4'd5, 4'd6, 4'd7: begin
        ch = (int'(a) - 4) / 2;
        if (mq[ch].size() == 0) return 32'd0;
        return a[0] ? mq[ch][0][63:32] : mq[ch][0][31:0];
      end
      default: return 32'd0;
    endcase
  endfunction

  task automatic rd(input logic [3:0] a, input string tag);
    @(negedge clk);
    re = 1'b1; addr = a;
    #1 check(tag, rdata, model_read(a));
    @(posedge clk);
    #1 re = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic pulse(input int c, input int hi, input int lo);
    @(negedge clk);
    trig[c] = 1'b1;
    repeat (hi) @(negedge clk);
    trig[c] = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic drain(input int c, input string tag);
    for (int k = 0; k < DEPTH + 1; k++) begin
      rd(4'(4 + 2 * c), tag);
      rd(4'(5 + 2 * c), tag);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    rd(4'd0, "R10 event"); rd(4'd1, "R10 mask"); rd(4'd2, "R10 status");
    rd(4'd4, "R10 data"); rd(4'd9, "R10 unmapped");
    // R8 arm both channels; R1 single capture
    wr(4'd1, 32'h3);
    rd(4'd1, "R8 mask readback");
    pulse(0, 3, 4);
    rd(4'd0, "R6 event set");
    rd(4'd2, "R4 valid");
    rd(4'd4, "R1 stamp lo"); rd(4'd5, "R1 stamp hi");
    rd(4'd2, "R4 valid after pop");
    rd(4'd5, "R5 empty read");
    // R2 ordering on both channels, interleaved
    pulse(0, 2, 3); pulse(1, 2, 3); pulse(0, 3, 3); pulse(1, 1, 4); pulse(0, 2, 5);
    rd(4'd2, "R4 both valid");
    drain(1, "R2 ch1 order");
    drain(0, "R2 ch0 order");
    // R3 overflow
    for (int k = 0; k < DEPTH + 2; k++) pulse(1, 2, 3);
    rd(4'd2, "R3 overflow set");
    drain(1, "R3 kept entries");
    wr(4'd2, 32'h0000_0004);
    rd(4'd2, "R3 overflow still set");
    wr(4'd2, 32'h0000_0008);
    rd(4'd2, "R3 overflow cleared");
    // R7 write-one-to-clear
    rd(4'd0, "R7 before");
    wr(4'd0, 32'h0);
    rd(4'd0, "R7 zero keeps");
    wr(4'd0, 32'h1);
    rd(4'd0, "R7 one clears");
    // R7 capture in the same cycle as a clear
    @(negedge clk); trig[0] = 1'b1;
    @(posedge clk); @(posedge clk);
    wr(4'd0, 32'h3);
    rd(4'd0, "R7 capture wins");
    @(negedge clk); trig[0] = 1'b0;
    // R8 arming clears stale event
    wr(4'd1, 32'h0);
    pulse(1, 2, 4);
    rd(4'd0, "R8 pending masked");
    wr(4'd1, 32'h2);
    rd(4'd0, "R8 arm clears");
    rd(4'd1, "R8 mask");
    // R1 long high level stores one stamp
    drain(0, "R1 flush"); drain(1, "R1 flush");
    pulse(0, 12, 4);
    rd(4'd2, "R1 one entry");
    rd(4'd4, "R1 lo"); rd(4'd5, "R1 hi");
    rd(4'd2, "R1 none left");
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule